// File: doc/BRIEF.md
# Codec Power-Control Sequencer

This block holds the power-enable state of an audio converter front end. Its eight-bit control register has one bit per analog block. A single-cycle write strobe loads all eight bits at once, and a read port returns the stored value at all times. Each stored bit drives its own enable output. An active-low hardware power-down pin overrides every enable output, but it never changes the stored bits. The pin is synchronized through two flip-flops before it is used.

The ADC has a warm-up gate. When the effective ADC enable turns on, an up-counter clocked by a one-cycle sample-rate strobe must see `INIT_SAMPLES` strobes (2081 by default) before the ADC data-valid output rises. A small state machine runs this gate. Its states are `ADC_OFF`, `ADC_WARM` and `ADC_READY`. The transitions are:
- `OFF->WARM`: the effective ADC enable turns on, and the counter clears.
- `WARM->READY`: the final strobe arrives.
- `WARM->OFF` and `READY->OFF`: the ADC bit clears or hardware power-down asserts.

Because any loss of the enable sends the machine to `ADC_OFF`, a re-enable always restarts the full count.

The block also produces three combinational outputs:
- A global power-down flag.
- A hold signal that keeps the microphone preamplifier gain at its default while the microphone block is off.
- A configuration-error flag, raised when some block is enabled without the common reference.

Top module: `pwr_seq_ctl`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, `wr_data` is stored at that edge, and `rd_data` returns the stored byte from then on, whether or not power-down is active.
- R2: After reset the stored byte is 0x00. Without a write the stored byte never changes.
- R3: The bit map is: bit 0 ADC, bit 1 mic input, bit 2 aux input, bit 3 mono line out, bit 4 line out, bit 5 mono beep, bit 6 stereo beep, bit 7 common reference. While power-down is inactive, `blk_en` equals the stored byte, bit for bit.
- R4: Power-down takes effect at the second rising edge that samples `hw_pd_n` low. From then on `blk_en` is 0x00. The stored byte is left unchanged, and `blk_en` returns to the stored byte two edges after the pin goes high.
- R5: After the effective ADC enable turns on, `adc_valid` stays low until `INIT_SAMPLES` `fs_tick` strobes have been counted in the warm-up state. It then goes high and stays high while the enable holds.
- R6: Clearing ADC bit 0 drops `adc_valid` immediately. Setting the bit again, even in the middle of a count, restarts the full count.
- R7: Hardware power-down aborts a warm-up in progress. After release, the full count runs again.
- R8: `all_pd` is high exactly when the stored byte is 0x00 or power-down is active.
- R9: `mic_gain_clr` is high exactly when the effective mic enable (bit 1 gated by power-down) is low.
- R10: `cfg_err` is high exactly when bit 7 of the stored byte is 0 and any of bits 6..0 is 1, regardless of power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_pd_n | input | 1 | Asynchronous active-low hardware power-down |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| fs_tick | input | 1 | One-cycle sample-rate strobe |
| rd_data | output | 8 | Stored register value |
| blk_en | output | 8 | Per-block enables after power-down gating |
| adc_valid | output | 1 | ADC data valid after warm-up |
| all_pd | output | 1 | Global power-down indication |
| mic_gain_clr | output | 1 | Hold mic preamplifier gain at default |
| cfg_err | output | 1 | Block enabled without common reference |

## Verification
The assertions rely on three properties of the inputs:
- `hw_pd_n` is driven to a known level from time zero, so looking two cycles back at it never sees an unknown value.
- `fs_tick` is a single-cycle pulse.
- `wr_en` is the only source of change for the stored byte.

The bench meets these conditions by driving every input from the falling clock edge. It sets the pin high before reset is released and spaces the strobes four cycles apart. The warm-up checks use a reduced count, so that an abort can be tried after every possible number of counted strobes.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    localparam int NUM_BLOCKS = 8;
    localparam int BIT_ADC    = 0;
    localparam int BIT_MIC    = 1;
    localparam int BIT_AUX    = 2;
    localparam int BIT_MONO   = 3;
    localparam int BIT_LINE   = 4;
    localparam int BIT_BEEP_M = 5;
    localparam int BIT_BEEP_S = 6;
    localparam int BIT_REF    = 7;

    typedef enum logic [1:0] {
        ADC_OFF   = 2'd0,
        ADC_WARM  = 2'd1,
        ADC_READY = 2'd2
    } adc_state_e;
endpackage

// File: rtl/pwr_pd_sync.sv
module pwr_pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pd_active
);
    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], pin_n};
            end
        end
    endgenerate

    // Treated as powered down until the synchronized pin reads high.
    assign pd_active = !sync_q[STAGES-1];
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] ctl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ctl_q <= '0;
        else if (wr_en) ctl_q <= wr_data;
    end
endmodule

// File: rtl/pwr_adc_init.sv
module pwr_adc_init
    import pwr_seq_pkg::*;
#(
    parameter int INIT_SAMPLES = 2081
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adc_on,
    input  logic fs_tick,
    output logic adc_valid
);
    localparam int CW = (INIT_SAMPLES > 1) ? $clog2(INIT_SAMPLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(INIT_SAMPLES - 1);

    adc_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ADC_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ADC_OFF: begin
                cnt_d = '0;
                if (adc_on) state_d = ADC_WARM;
            end
            ADC_WARM: begin
                if (!adc_on) begin
                    state_d = ADC_OFF;
                end else if (fs_tick) begin
                    if (cnt_q == LAST) state_d = ADC_READY;
                    else               cnt_d   = cnt_q + 1'b1;
                end
            end
            ADC_READY: begin
                if (!adc_on) state_d = ADC_OFF;
            end
            default: state_d = ADC_OFF;
        endcase
    end

    // Output logic.
    always_comb begin
        adc_valid = 1'b0;
        unique case (state_q)
            ADC_READY: adc_valid = adc_on;
            default:   adc_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwr_seq_ctl.sv
module pwr_seq_ctl
    import pwr_seq_pkg::*;
#(
    parameter int INIT_SAMPLES = 2081,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_pd_n,
    input  logic                  wr_en,
    input  logic [NUM_BLOCKS-1:0] wr_data,
    input  logic                  fs_tick,
    output logic [NUM_BLOCKS-1:0] rd_data,
    output logic [NUM_BLOCKS-1:0] blk_en,
    output logic                  adc_valid,
    output logic                  all_pd,
    output logic                  mic_gain_clr,
    output logic                  cfg_err
);
    logic                  pd_active;
    logic [NUM_BLOCKS-1:0] ctl_q;

    pwr_pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (hw_pd_n),
        .pd_active (pd_active)
    );

    pwr_ctl_reg #(.WIDTH(NUM_BLOCKS)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl_q   (ctl_q)
    );

    // Each stored bit is gated by the synchronized power-down.
    generate
        for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_gate
            assign blk_en[i] = ctl_q[i] & ~pd_active;
        end
    endgenerate

    pwr_adc_init #(.INIT_SAMPLES(INIT_SAMPLES)) u_adc (
        .clk       (clk),
        .rst_n     (rst_n),
        .adc_on    (blk_en[BIT_ADC]),
        .fs_tick   (fs_tick),
        .adc_valid (adc_valid)
    );

    assign rd_data      = ctl_q;
    assign all_pd       = pd_active | (ctl_q == '0);
    assign mic_gain_clr = ~blk_en[BIT_MIC];
    assign cfg_err      = ~ctl_q[BIT_REF] & (|ctl_q[BIT_REF-1:0]);
endmodule

// File: rtl/pwr_seq_ctl_chk.sv
module pwr_seq_ctl_chk
    import pwr_seq_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  hw_pd_n,
    input logic                  wr_en,
    input logic [NUM_BLOCKS-1:0] wr_data,
    input logic                  fs_tick,
    input logic [NUM_BLOCKS-1:0] rd_data,
    input logic [NUM_BLOCKS-1:0] blk_en,
    input logic                  adc_valid,
    input logic                  all_pd,
    input logic                  mic_gain_clr,
    input logic                  cfg_err
);
    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    assert_enables_follow_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en & ~rd_data) == '0);

    assert_pd_forces_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hw_pd_n, 2) |-> blk_en == '0);

    assert_valid_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_valid) |-> $past(fs_tick));

    assert_valid_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_valid |-> blk_en[BIT_ADC]);

    assert_zero_store_is_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data == '0) |-> all_pd);

    assert_mic_off_clears_gain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[BIT_MIC] |-> mic_gain_clr);

    assert_err_needs_ref_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !rd_data[BIT_REF]);
endmodule

bind pwr_seq_ctl pwr_seq_ctl_chk u_chk (.*);

// File: tb/pwr_seq_ctl_bench.sv
module pwr_seq_ctl_bench;
    localparam int N = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_pd_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fs_tick = 1'b0;
    logic [7:0] rd_data, blk_en;
    logic       adc_valid, all_pd, mic_gain_clr, cfg_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pwr_seq_ctl #(.INIT_SAMPLES(N)) u_pwr_seq_ctl (
        .clk(clk), .rst_n(rst_n), .hw_pd_n(hw_pd_n), .wr_en(wr_en),
        .wr_data(wr_data), .fs_tick(fs_tick), .rd_data(rd_data),
        .blk_en(blk_en), .adc_valid(adc_valid), .all_pd(all_pd),
        .mic_gain_clr(mic_gain_clr), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            summary();
        end
    end

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One strobe, then three quiet cycles.
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fs_tick = 1'b1;
            @(negedge clk); fs_tick = 1'b0;
            idle(2);
        end
    endtask

    task automatic set_pd(input logic low);
        @(negedge clk); hw_pd_n = ~low;
        idle(3);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(3);
        // R2 reset state
        chk("R2 reset store", rd_data, 8'h00);
        chk("R3 reset enables", blk_en, 8'h00);
        chk("R8 reset all_pd", all_pd, 1);
        chk("R5 reset valid", adc_valid, 0);

        // R1 R3 R8 R9 R10 sweep over every byte.
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            wr(b);
            chk("R1 readback", rd_data, b);
            chk("R3 enables", blk_en, b);
            chk("R8 all_pd", all_pd, (b == 0));
            chk("R9 mic gain", mic_gain_clr, !b[1]);
            chk("R10 cfg_err", cfg_err, (!b[7] && (b[6:0] != 0)));
            idle(2);
            chk("R2 no write hold", rd_data, b);
        end

        // R4 hardware power-down timing and gating.
        wr(8'hA5);
        @(negedge clk); hw_pd_n = 1'b0;
        @(negedge clk);
        chk("R4 one edge not yet", blk_en, 8'hA5);
        @(negedge clk);
        chk("R4 second edge off", blk_en, 8'h00);
        for (int v = 0; v < 256; v += 17) begin
            logic [7:0] b;
            b = 8'(v);
            wr(b);
            chk("R1 readback under pd", rd_data, b);
            chk("R4 enables off", blk_en, 8'h00);
            chk("R8 all_pd under pd", all_pd, 1);
            chk("R9 mic gain under pd", mic_gain_clr, 1);
            chk("R10 cfg_err under pd", cfg_err, (!b[7] && (b[6:0] != 0)));
        end
        wr(8'h93);
        set_pd(1'b0);
        chk("R4 released store", blk_en, 8'h93);
        chk("R4 store kept", rd_data, 8'h93);

        // R5 full warm-up.
        wr(8'h80); idle(2);
        wr(8'h81); idle(2);
        ticks(N - 1);
        chk("R5 low before final tick", adc_valid, 0);
        ticks(1);
        chk("R5 high after final tick", adc_valid, 1);
        ticks(3);
        chk("R5 stays high", adc_valid, 1);

        // R6 restart after a clear at every count.
        for (int k = 0; k < N; k++) begin
            wr(8'h80); idle(1);
            chk("R6 clear drops valid", adc_valid, 0);
            wr(8'h81); idle(2);
            ticks(k);
            wr(8'h80);
            wr(8'h81); idle(2);
            ticks(N - 1);
            chk("R6 restart low", adc_valid, 0);
            ticks(1);
            chk("R6 restart high", adc_valid, 1);
        end

        // R7 power-down aborts warm-up at every count.
        for (int k = 0; k < N; k++) begin
            wr(8'h80); idle(1);
            wr(8'h81); idle(2);
            ticks(k);
            set_pd(1'b1);
            chk("R7 valid low in pd", adc_valid, 0);
            set_pd(1'b0);
            ticks(N - 1);
            chk("R7 rerun low", adc_valid, 0);
            ticks(1);
            chk("R7 rerun high", adc_valid, 1);
        end

        summary();
    end
endmodule